// File: doc/BRIEF.md
# Halving Tree Sum Reducer

This block adds up a set of N signed partial sums held in an internal register array and leaves the grand total in entry 0. Each reduction step halves an active count. Every entry below the new count then adds the entry that sits that many places above it. When the active count is odd at the start of a step, entry 0 first takes in the element at the top of the active range, so counts that are not powers of two reduce correctly. The array is widened so that the total of N worst-case inputs always fits.

The entries are filled in one of two ways. A full vector can be captured together with the start pulse, or single entries can be written one at a time while the block is idle. The pairwise adds of a step are shared across a bounded bank of adder lanes, several cycles per step if needed. The next step begins only once every add of the current step has been written back, which acts as the barrier between steps. A one-cycle done pulse marks the point at which the total is valid.

Top module: `halving_sum_reducer`

## Requirements
- R1: After done, `total` equals the exact sum of all N loaded entries, each treated as a two's-complement value `IN_W` bits wide.
- R2: `total` is `IN_W + ceil(log2 N)` bits wide and never overflows, even when every entry is the largest positive value or the most negative value.
- R3: Counts that are not powers of two reduce correctly. Whenever the active count is odd, entry 0 absorbs the entry at index count−1 before the count is halved, so a value that lands on that index is still counted.
- R4: `done` is high for exactly one cycle. It rises L cycles after the clock edge that accepts `start`. L is the sum over all steps with count c > 1 of (1 if c is odd) + ceil((c/2)/LANES), where c/2 is integer division and c then becomes c/2.
- R5: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high, and `busy` is low while `done` is high.
- R6: A `start` pulse while `busy` is high is ignored. It neither reloads the entries nor changes the latency or the total of the run in progress.
- R7: An entry write (`wr_en`) while `busy` is high is ignored and does not change the total.
- R8: While idle, `wr_en` writes `wr_data` sign-extended into entry `wr_idx`. A start with `take_vec` = 0 then reduces the stored entries.
- R9: A start with `take_vec` = 1 captures entry i from bits [i·IN_W +: IN_W] of `vec_in` and reduces those values.
- R10: With N = 1, `done` rises in the cycle right after the start edge (L = 0), and `total` equals the single input.
- R11: While reset is held and right after it is released, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction (accepted only when idle) |
| take_vec | input | 1 | With start: capture all entries from `vec_in` |
| vec_in | input | N_ENT·IN_W | Parallel load vector, entry i in bits [i·IN_W +: IN_W] |
| wr_en | input | 1 | Write a single entry (idle only) |
| wr_idx | input | IDX_W | Entry index for a single write |
| wr_data | input | IN_W | Signed value for a single write |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse: total is valid |
| total | output | RES_W | Contents of entry 0 (the total after done) |

## Verification
The main reduction is driven with all-ones, an index ramp, alternating-sign values, all largest-positive and all most-negative entries. The ramp exposes any mis-paired index, and the two extremes tell a correctly widened adder from one that wraps. A pattern with one nonzero value at index 74 of 100 moves that value into index 24 when the count is 25, so it is counted only if the odd-count fold works. A seven-entry instance loaded by single writes checks the fold at two odd counts with a lane bank narrower than a step. A one-entry instance checks the immediate-done case. Latency is compared against the step formula, and stray start pulses and writes are injected mid-run to show that they leave both timing and total untouched.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FOLD = 2'd1,
    PH_PAIR = 2'd2
  } phase_t;
endpackage

// File: rtl/hsr_ctrl.sv
// Step sequencer: owns the active count, the chunk base within a step and
// the done pulse. A step ends only after its last chunk is written back.
module hsr_ctrl
  import hsr_pkg::*;
#(
  parameter int N_ENT = 100,
  parameter int LANES = 8,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] half,
  output logic [CW-1:0] base,
  output logic          accept,
  output logic          done
);
  localparam logic [CW:0]   LANE_STEP = (CW+1)'(LANES);
  localparam logic [CW-1:0] CNT_INIT  = CW'(N_ENT);
  localparam bit            INIT_ODD  = (N_ENT % 2) == 1;
  localparam bit            SINGLE    = (N_ENT == 1);

  phase_t        phase_n;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] base_n;
  logic          done_n;
  logic          last_chunk;

  assign half       = cnt >> 1;
  assign accept     = start && (phase == PH_IDLE);
  assign last_chunk = ({1'b0, base} + LANE_STEP) >= {1'b0, half};

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    base_n  = base;
    done_n  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (accept) begin
          cnt_n  = CNT_INIT;
          base_n = '0;
          if (SINGLE) begin
            done_n = 1'b1;
          end else if (INIT_ODD) begin
            phase_n = PH_FOLD;
          end else begin
            phase_n = PH_PAIR;
          end
        end
      end
      PH_FOLD: begin
        phase_n = PH_PAIR;
        base_n  = '0;
      end
      PH_PAIR: begin
        if (last_chunk) begin
          cnt_n  = half;
          base_n = '0;
          if (half == CW'(1)) begin
            phase_n = PH_IDLE;
            done_n  = 1'b1;
          end else if (half[0]) begin
            phase_n = PH_FOLD;
          end else begin
            phase_n = PH_PAIR;
          end
        end else begin
          base_n = base + CW'(LANES);
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      base  <= '0;
      done  <= 1'b0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      base  <= base_n;
      done  <= done_n;
    end
  end
endmodule

// File: rtl/hsr_lanes.sv
// Bounded bank of adders shared by every step of the reduction.
module hsr_lanes #(
  parameter int LANES = 8,
  parameter int RES_W = 23
) (
  input  logic [LANES-1:0][RES_W-1:0] opa,
  input  logic [LANES-1:0][RES_W-1:0] opb,
  output logic [LANES-1:0][RES_W-1:0] sum
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sum[k] = opa[k] + opb[k];
  end
endmodule

// File: rtl/hsr_store.sv
// Entry array with a full-vector load, lane write-back, single writes and
// per-lane read ports. Data registers carry no reset.
module hsr_store #(
  parameter int N_ENT = 100,
  parameter int IN_W  = 16,
  parameter int RES_W = 23,
  parameter int LANES = 8,
  parameter int CW    = 8
) (
  input  logic                        clk,
  input  logic                        ld_all,
  input  logic [N_ENT*IN_W-1:0]       vec_in,
  input  logic                        wr_en,
  input  logic [CW-1:0]               wr_idx,
  input  logic [IN_W-1:0]             wr_data,
  input  logic [LANES-1:0]            upd_en,
  input  logic [LANES-1:0][CW-1:0]    upd_idx,
  input  logic [LANES-1:0][RES_W-1:0] upd_val,
  input  logic [LANES-1:0][CW-1:0]    rda_idx,
  input  logic [LANES-1:0][CW-1:0]    rdb_idx,
  output logic [LANES-1:0][RES_W-1:0] rda,
  output logic [LANES-1:0][RES_W-1:0] rdb,
  output logic [RES_W-1:0]            head
);
  logic [RES_W-1:0] ent_q [N_ENT];
  logic [RES_W-1:0] wr_ext;

  assign wr_ext = RES_W'($signed(wr_data));

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic             we;
    logic [RES_W-1:0] d;
    logic [RES_W-1:0] q;

    always_comb begin
      we = 1'b0;
      d  = q;
      if (ld_all) begin
        we = 1'b1;
        d  = RES_W'($signed(vec_in[e*IN_W +: IN_W]));
      end else begin
        for (int k = 0; k < LANES; k++) begin
          if (upd_en[k] && (upd_idx[k] == CW'(e))) begin
            we = 1'b1;
            d  = upd_val[k];
          end
        end
        if (wr_en && (wr_idx == CW'(e))) begin
          we = 1'b1;
          d  = wr_ext;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (we) q <= d;
    end

    assign ent_q[e] = q;
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rda[k] = '0;
      rdb[k] = '0;
      for (int e = 0; e < N_ENT; e++) begin
        if (rda_idx[k] == CW'(e)) rda[k] = ent_q[e];
        if (rdb_idx[k] == CW'(e)) rdb[k] = ent_q[e];
      end
    end
  end

  assign head = ent_q[0];
endmodule

// File: rtl/halving_sum_reducer.sv
module halving_sum_reducer
  import hsr_pkg::*;
#(
  parameter int N_ENT = 100,
  parameter int IN_W  = 16,
  parameter int LANES = 8,
  parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  parameter int RES_W = IN_W + $clog2(N_ENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  take_vec,
  input  logic [N_ENT*IN_W-1:0] vec_in,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [IN_W-1:0]       wr_data,
  output logic                  busy,
  output logic                  done,
  output logic [RES_W-1:0]      total
);
  localparam int CW = $clog2(N_ENT + 1) + 1;

  phase_t                      phase;
  logic [CW-1:0]               cnt;
  logic [CW-1:0]               half;
  logic [CW-1:0]               base;
  logic                        accept;
  logic [LANES-1:0]            lane_en;
  logic [LANES-1:0][CW-1:0]    lane_ia;
  logic [LANES-1:0][CW-1:0]    lane_ib;
  logic [LANES-1:0][RES_W-1:0] lane_a;
  logic [LANES-1:0][RES_W-1:0] lane_b;
  logic [LANES-1:0][RES_W-1:0] lane_sum;
  logic                        wr_ok;

  hsr_ctrl #(
    .N_ENT(N_ENT),
    .LANES(LANES),
    .CW   (CW)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase),
    .cnt   (cnt),
    .half  (half),
    .base  (base),
    .accept(accept),
    .done  (done)
  );

  // Operand selection: a fold step uses lane 0 only; a pair step covers
  // indices base .. base+LANES-1 that lie below the halved count.
  for (genvar k = 0; k < LANES; k++) begin : g_opsel
    always_comb begin
      lane_ia[k] = base + CW'(k);
      lane_ib[k] = base + CW'(k) + half;
      lane_en[k] = (phase == PH_PAIR) && ((base + CW'(k)) < half);
      if ((k == 0) && (phase == PH_FOLD)) begin
        lane_ia[k] = '0;
        lane_ib[k] = cnt - CW'(1);
        lane_en[k] = 1'b1;
      end
    end
  end

  hsr_lanes #(
    .LANES(LANES),
    .RES_W(RES_W)
  ) u_lanes (
    .opa(lane_a),
    .opb(lane_b),
    .sum(lane_sum)
  );

  assign wr_ok = wr_en && (phase == PH_IDLE);

  hsr_store #(
    .N_ENT(N_ENT),
    .IN_W (IN_W),
    .RES_W(RES_W),
    .LANES(LANES),
    .CW   (CW)
  ) u_store (
    .clk    (clk),
    .ld_all (accept && take_vec),
    .vec_in (vec_in),
    .wr_en  (wr_ok),
    .wr_idx (CW'(wr_idx)),
    .wr_data(wr_data),
    .upd_en (lane_en),
    .upd_idx(lane_ia),
    .upd_val(lane_sum),
    .rda_idx(lane_ia),
    .rdb_idx(lane_ib),
    .rda    (lane_a),
    .rdb    (lane_b),
    .head   (total)
  );

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/hsr_checker.sv
module hsr_checker #(
  parameter int N_ENT = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  localparam int LIM  = 2 * N_ENT + 4;
  localparam int LW   = $clog2(LIM + 1) + 1;

  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (busy) begin
      run_len <= run_len + LW'(1);
    end else begin
      run_len <= '0;
    end
  end

  // R4: done lasts a single cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: a run cannot stay busy past a bound set by the entry count
  a_r4_bounded_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < LW'(LIM)));

  // R5: busy and done never overlap
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: a run ends only together with done
  a_r5_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5 / R10: an idle start always leads to busy or done next cycle
  a_r5_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done));

  // R11: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r11_reset_quiet: assert (!busy && !done);
    end
  end
endmodule

bind halving_sum_reducer hsr_checker #(.N_ENT(N_ENT)) u_hsr_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .busy (busy),
  .done (done)
);

// File: tb/tb_halving_sum_reducer.sv
module tb_halving_sum_reducer;
  localparam int PERIOD = 10;

  localparam int NA = 100, WA = 16, LA = 8;
  localparam int NB = 7,   WB = 8,  LB = 2;
  localparam int NC = 1,   WC = 8,  LC = 1;
  localparam int RA = WA + $clog2(NA);
  localparam int RB = WB + $clog2(NB);
  localparam int RC = WC + $clog2(NC);

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_fail;

  // instance A (reference count)
  logic              a_start, a_take, a_wr;
  logic [NA*WA-1:0]  a_vec;
  logic [6:0]        a_idx;
  logic [WA-1:0]     a_wd;
  logic              a_busy, a_done;
  logic [RA-1:0]     a_tot;
  // instance B (small odd count, narrow lane bank)
  logic              b_start, b_take, b_wr;
  logic [NB*WB-1:0]  b_vec;
  logic [2:0]        b_idx;
  logic [WB-1:0]     b_wd;
  logic              b_busy, b_done;
  logic [RB-1:0]     b_tot;
  // instance C (single entry)
  logic              c_start, c_take, c_wr;
  logic [NC*WC-1:0]  c_vec;
  logic [0:0]        c_idx;
  logic [WC-1:0]     c_wd;
  logic              c_busy, c_done;
  logic [RC-1:0]     c_tot;

  halving_sum_reducer #(.N_ENT(NA), .IN_W(WA), .LANES(LA)) dut (
    .clk(clk), .rst_n(rst_n), .start(a_start), .take_vec(a_take),
    .vec_in(a_vec), .wr_en(a_wr), .wr_idx(a_idx), .wr_data(a_wd),
    .busy(a_busy), .done(a_done), .total(a_tot));

  halving_sum_reducer #(.N_ENT(NB), .IN_W(WB), .LANES(LB)) dut_b (
    .clk(clk), .rst_n(rst_n), .start(b_start), .take_vec(b_take),
    .vec_in(b_vec), .wr_en(b_wr), .wr_idx(b_idx), .wr_data(b_wd),
    .busy(b_busy), .done(b_done), .total(b_tot));

  halving_sum_reducer #(.N_ENT(NC), .IN_W(WC), .LANES(LC)) dut_c (
    .clk(clk), .rst_n(rst_n), .start(c_start), .take_vec(c_take),
    .vec_in(c_vec), .wr_en(c_wr), .wr_idx(c_idx), .wr_data(c_wd),
    .busy(c_busy), .done(c_done), .total(c_tot));

  initial begin
    clk = 1'b0;
    forever #(PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int step_latency(input int n, input int lanes);
    int c = n;
    int l = 0;
    while (c > 1) begin
      if (c % 2 == 1) l++;
      l += ((c / 2) + lanes - 1) / lanes;
      c = c / 2;
    end
    return l;
  endfunction

  // kind: 0 ones, 1 ramp, 2 max positive, 3 most negative,
  //       4 single value at index 74, 5 alternating signs
  function automatic int pattern(input int kind, input int i, input int w);
    case (kind)
      0: return 1;
      1: return i;
      2: return (1 <<< (w - 1)) - 1;
      3: return -(1 <<< (w - 1));
      4: return (i == 74) ? 777 : 0;
      default: return (i % 2 == 0) ? (i * 37) : -(i * 53);
    endcase
  endfunction

  // R1 R2 R3 R4 R5 R6 R7 R9: full-vector run on instance A, optional noise
  task automatic run_a(input int kind, input bit noise, input string tag);
    longint exp = 0;
    int     n = 0;
    int     lat = step_latency(NA, LA);
    for (int i = 0; i < NA; i++) begin
      a_vec[i*WA +: WA] = WA'(pattern(kind, i, WA));
      exp += longint'(pattern(kind, i, WA));
    end
    @(negedge clk);
    a_take = 1'b1; a_start = 1'b1;
    @(negedge clk);
    a_start = 1'b0; a_take = 1'b0;
    while (!a_done && n < 1000) begin
      check(a_busy == 1'b1, {tag, " R5 busy during run"}, a_busy, 1);
      if (noise && n == 3) begin
        // R6: stray start with a new vector; R7: stray write to entry 0
        for (int i = 0; i < NA; i++) a_vec[i*WA +: WA] = WA'(5);
        a_start = 1'b1; a_take = 1'b1;
        a_wr = 1'b1; a_idx = 7'd0; a_wd = WA'(1234);
      end else begin
        a_start = 1'b0; a_take = 1'b0; a_wr = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    a_start = 1'b0; a_take = 1'b0; a_wr = 1'b0;
    check(n == lat, {tag, " R4 latency"}, n, lat);
    check(a_busy == 1'b0, {tag, " R5 idle at done"}, a_busy, 0);
    check($signed(a_tot) == exp, {tag, " R1 total"}, $signed(a_tot), exp);
    @(negedge clk);
    check(a_done == 1'b0, {tag, " R4 single-cycle done"}, a_done, 0);
    if (noise) begin
      repeat (4) begin
        check(a_done == 1'b0 && a_busy == 1'b0, {tag, " R6 no second run"}, a_done, 0);
        @(negedge clk);
      end
    end
  endtask

  // R3 R4 R8 R9: instance B, either single writes or vector load
  task automatic run_b(input int kind, input bit by_writes, input string tag);
    longint exp = 0;
    int     n = 0;
    int     lat = step_latency(NB, LB);
    for (int i = 0; i < NB; i++) exp += longint'(pattern(kind, i, WB));
    if (by_writes) begin
      for (int i = 0; i < NB; i++) begin
        @(negedge clk);
        b_wr = 1'b1; b_idx = 3'(i); b_wd = WB'(pattern(kind, i, WB));
      end
      @(negedge clk);
      b_wr = 1'b0;
    end else begin
      for (int i = 0; i < NB; i++) b_vec[i*WB +: WB] = WB'(pattern(kind, i, WB));
    end
    @(negedge clk);
    b_take = !by_writes; b_start = 1'b1;
    @(negedge clk);
    b_start = 1'b0; b_take = 1'b0;
    while (!b_done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n == lat, {tag, " R4 latency"}, n, lat);
    check($signed(b_tot) == exp, {tag, " R3 total"}, $signed(b_tot), exp);
    @(negedge clk);
  endtask

  // R10: single-entry instance
  task automatic run_c(input int val);
    @(negedge clk);
    c_vec = WC'(val); c_take = 1'b1; c_start = 1'b1;
    @(negedge clk);
    c_start = 1'b0; c_take = 1'b0;
    check(c_done == 1'b1, "R10 immediate done", c_done, 1);
    check($signed(c_tot) == val, "R10 total", $signed(c_tot), val);
    @(negedge clk);
    check(c_done == 1'b0, "R10 done single cycle", c_done, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    a_start = 0; a_take = 0; a_wr = 0; a_vec = '0; a_idx = '0; a_wd = '0;
    b_start = 0; b_take = 0; b_wr = 0; b_vec = '0; b_idx = '0; b_wd = '0;
    c_start = 0; c_take = 0; c_wr = 0; c_vec = '0; c_idx = '0; c_wd = '0;
    repeat (3) @(negedge clk);
    check(!a_busy && !a_done && !b_busy && !b_done && !c_busy && !c_done,
          "R11 reset held", a_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!a_busy && !a_done, "R11 after release", a_done, 0);

    run_a(0, 1'b0, "R1 R9 ones");
    run_a(1, 1'b0, "R1 ramp");
    run_a(5, 1'b0, "R1 alternating");
    run_a(2, 1'b0, "R2 max positive");
    run_a(3, 1'b0, "R2 most negative");
    run_a(4, 1'b0, "R3 fold at index 74");
    run_a(1, 1'b1, "R6 R7 stray inputs");
    run_b(1, 1'b1, "R8 writes ramp");
    run_b(3, 1'b1, "R8 writes negative");
    run_b(5, 1'b0, "R9 vector alternating");
    run_c(-5);
    run_c(100);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule